// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Threshold Interrupts

This block sits between a processor register bus and an audio serializer. Software writes 32-bit sample words into a queue through a data register. The serializer pulls one word for each channel slot while transmission is enabled. Each audio frame takes two words, one for each channel.

The block has a small register file that holds the configuration word, the interrupt source mask and the interrupt status. The configuration word is passed out whole to the serializer. Two live conditions are reported: the queue is empty (underrun), and the queue fill is below a threshold (level). The threshold is the queue depth shifted right by a 4-bit trigger field. A single interrupt line is raised when the global interrupt enable is set and an unmasked condition is present. Software can use the level interrupt to top up the queue before it drains.

Top module: `pcm_txq_regs`

## Requirements
- R1: After reset the configuration word, the mask and the queue fill are all 0, and the interrupt output is low.
- R2: Reads use the word index: 0 returns the VERSION parameter, 1 the configuration word, 2 the mask in bits 1:0, and 3 the status in bits 1:0. Indices 4 to 7 are write-only and read as 0.
- R3: A write to index 0 has no effect, so the version value stays as it was.
- R4: The configuration word at index 1 stores and returns all 32 bits. The mask at index 2 keeps only bits 1:0.
- R5: Each write to index 4 appends one word to the queue. Writes to indices 5, 6 and 7 leave the queue unchanged.
- R6: A write to index 4 while the queue holds 2^DEPTH_LOG2 words is dropped. The fill stays at full and the stored contents are kept.
- R7: When cons_pop is high, configuration bit 0 (transmit enable) is set and the queue is not empty, the head word on cons_data is removed. Words leave in the order they were written, and the fill drops by one.
- R8: cons_pop has no effect while configuration bit 0 is clear or while the queue is empty.
- R9: Status bit 0 (underrun) is 1 one cycle after a cycle in which the fill is 0, and 0 otherwise.
- R10: Status bit 1 (level) is 1 one cycle after a cycle in which the fill is below 2^DEPTH_LOG2 shifted right by configuration bits 27:24, and 0 otherwise.
- R11: irq is high exactly when configuration bit 1 (interrupt enable) is set and the AND of status bits 1:0 and mask bits 1:0 is nonzero.
- R12: A write to index 3 clears the status bits that are 1 in the write data, for one cycle only. A bit whose condition still holds reads as 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index (byte offset divided by 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_word |
| cons_pop | input | 1 | Serializer request to take the head word |
| cons_data | output | 32 | Head word of the queue |
| cons_fill | output | DEPTH_LOG2+1 | Number of words in the queue |
| cfg_word | output | 32 | Configuration word passed to the serializer |
| irq | output | 1 | Interrupt request |

## Verification
The threshold compare is swept over every fill from empty to full against every value of the 4-bit trigger field. This exposes off-by-one errors at each threshold boundary, as well as shifts that saturate to zero and so never assert level. The interrupt gate is tried with every mask and enable combination in two cases: with only underrun present, and with only level present. This shows whether each mask bit gates its own source. Data words carry distinct values, so the pop order, the dropped push into a full queue and the pops blocked by disable or empty can each be told apart by the data that comes out.

// File: rtl/pcm_txq_regs.sv
module pcm_txq_regs #(
  parameter int          DEPTH_LOG2 = 11,
  parameter logic [31:0] VERSION    = 32'h0002_0100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [2:0]            reg_word,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  cons_pop,
  output logic [31:0]           cons_data,
  output logic [DEPTH_LOG2:0]   cons_fill,
  output logic [31:0]           cfg_word,
  output logic                  irq
);
  localparam int FW = DEPTH_LOG2 + 1;
  localparam logic [FW-1:0] FULL = FW'(1 << DEPTH_LOG2);

  logic [31:0]           mem [1 << DEPTH_LOG2];
  logic [DEPTH_LOG2-1:0] wp, rp;
  logic [FW-1:0]         fill;
  logic [31:0]           cfg_q;
  logic [1:0]            mask_q, status_q;

  wire push = reg_wr && (reg_word == 3'd4) && (fill != FULL);
  wire pop  = cons_pop && cfg_q[0] && (fill != '0);
  wire [FW-1:0] thr  = FULL >> cfg_q[27:24];
  wire [1:0]    live = {fill < thr, fill == '0};
  wire [1:0]    clr  = (reg_wr && reg_word == 3'd3) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      mask_q   <= '0;
      status_q <= '0;
      wp       <= '0;
      rp       <= '0;
      fill     <= '0;
    end else begin
      if (reg_wr && reg_word == 3'd1) cfg_q  <= reg_wdata;
      if (reg_wr && reg_word == 3'd2) mask_q <= reg_wdata[1:0];
      status_q <= live & ~clr;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= reg_wdata;
  end

  always_comb begin
    case (reg_word)
      3'd0:    reg_rdata = VERSION;
      3'd1:    reg_rdata = cfg_q;
      3'd2:    reg_rdata = {30'b0, mask_q};
      3'd3:    reg_rdata = {30'b0, status_q};
      default: reg_rdata = '0;
    endcase
  end

  assign cons_data = mem[rp];
  assign cons_fill = fill;
  assign cfg_word  = cfg_q;
  assign irq       = cfg_q[1] & |(status_q & mask_q);
endmodule

module pcm_txq_regs_chk #(
  parameter int          DEPTH_LOG2 = 11,
  parameter logic [31:0] VERSION    = 32'h0002_0100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [2:0]          reg_word,
  input logic [31:0]         reg_rdata,
  input logic                cons_pop,
  input logic [DEPTH_LOG2:0] fill,
  input logic [31:0]         cfg_q,
  input logic [1:0]          status_q,
  input logic                irq
);
  localparam logic [DEPTH_LOG2:0] FULL = (DEPTH_LOG2+1)'(1 << DEPTH_LOG2);

  p_version_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word == 3'd0) |-> (reg_rdata == VERSION));

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);

  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FULL && !(cons_pop && cfg_q[0])) |=> (fill == FULL));

  p_pop_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[0] && !(reg_wr && reg_word == 3'd4)) |=> (fill == $past(fill)));

  p_underrun_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[0] |-> ($past(fill) == '0));

  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[1] |-> !irq);
endmodule

bind pcm_txq_regs pcm_txq_regs_chk #(.DEPTH_LOG2(DEPTH_LOG2), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
  .reg_rdata(reg_rdata), .cons_pop(cons_pop), .fill(fill), .cfg_q(cfg_q),
  .status_q(status_q), .irq(irq));

// File: tb/tb_pcm_txq_regs.sv
module tb_pcm_txq_regs;
  localparam int DL = 4;
  localparam int DEPTH = 1 << DL;
  localparam logic [31:0] VER = 32'h0002_0100;

  logic clk = 0, rst_n = 0, reg_wr = 0, cons_pop = 0;
  logic [2:0] reg_word = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, cons_data, cfg_word;
  logic [DL:0] cons_fill;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] expq [DEPTH];

  always #10 clk = ~clk;

  pcm_txq_regs #(.DEPTH_LOG2(DL), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cons_pop(cons_pop),
    .cons_data(cons_data), .cons_fill(cons_fill), .cfg_word(cfg_word), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_word = w; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    reg_word = w; #1; d = reg_rdata;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic pop_one();
    @(negedge clk); cons_pop = 1;
    @(negedge clk); cons_pop = 0;
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1
    check(cons_fill == 0, "R1 fill", 32'(cons_fill), 0);
    check(irq == 0, "R1 irq", 32'(irq), 0);
    rd(3'd1, v); check(v == 0, "R1 cfg", v, 0);
    rd(3'd2, v); check(v == 0, "R1 mask", v, 0);
    // R2, R3
    rd(3'd0, v); check(v == VER, "R2 version", v, VER);
    wr(3'd0, 32'hFFFF_FFFF); settle();
    rd(3'd0, v); check(v == VER, "R3 version read-only", v, VER);
    // R4
    wr(3'd1, 32'hA5C3_7E18); rd(3'd1, v); check(v == 32'hA5C3_7E18, "R4 cfg", v, 32'hA5C3_7E18);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check(v == 32'h3, "R4 mask", v, 3);
    wr(3'd2, 32'h0);
    // R5
    for (int w = 5; w < 8; w++) wr(3'(w), 32'h1234_0000 + 32'(w));
    settle(); check(cons_fill == 0, "R5 ignored data regs", 32'(cons_fill), 0);
    for (int w = 4; w < 8; w++) begin
      rd(3'(w), v); check(v == 0, "R2 write-only reads zero", v, 0);
    end
    wr(3'd4, 32'hBEEF_0001); check(cons_fill == 1, "R5 push", 32'(cons_fill), 1);
    wr(3'd1, 32'h1); pop_one();
    check(cons_fill == 0, "R7 single pop", 32'(cons_fill), 0);
    pop_one(); check(cons_fill == 0, "R8 pop when empty", 32'(cons_fill), 0);
    wr(3'd1, 32'h0);
    // R9, R10 sweep
    for (int f = 0; f <= DEPTH; f++) begin
      for (int lvl = 0; lvl < 16; lvl++) begin
        logic [1:0] e;
        wr(3'd1, 32'(lvl) << 24); settle();
        e = {(f < (DEPTH >> lvl)), (f == 0)};
        rd(3'd3, v);
        check(v[0] == e[0], "R9 underrun", v, 32'(e));
        check(v[1] == e[1], "R10 level", v, 32'(e));
      end
      if (f < DEPTH) begin
        expq[f] = 32'hC0DE_0000 + 32'(f * 7);
        wr(3'd4, expq[f]);
      end
    end
    // R6
    wr(3'd4, 32'hDEAD_DEAD); settle();
    check(cons_fill == DEPTH, "R6 full drop", 32'(cons_fill), DEPTH);
    // R8 disabled
    wr(3'd1, 32'h0); pop_one();
    check(cons_fill == DEPTH, "R8 pop while disabled", 32'(cons_fill), DEPTH);
    check(cons_data == expq[0], "R8 head kept", cons_data, expq[0]);
    // R7 ordered drain
    wr(3'd1, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      check(cons_data == expq[i], "R7 order", cons_data, expq[i]);
      pop_one();
      check(cons_fill == 5'(DEPTH - 1 - i), "R7 fill", 32'(cons_fill), 32'(DEPTH - 1 - i));
    end
    pop_one(); check(cons_fill == 0, "R8 pop empty", 32'(cons_fill), 0);
    // R11: scenario 0 underrun only (lvl 15), scenario 1 level only (2 words, lvl 1)
    for (int sc = 0; sc < 2; sc++) begin
      logic [1:0] st;
      if (sc == 1) begin wr(3'd4, 32'h1); wr(3'd4, 32'h2); end
      st = (sc == 0) ? 2'b01 : 2'b10;
      for (int ie = 0; ie < 2; ie++)
        for (int m = 0; m < 4; m++) begin
          bit e;
          wr(3'd1, ((sc == 0) ? 32'h0F00_0000 : 32'h0100_0000) | (32'(ie) << 1));
          wr(3'd2, 32'(m)); settle();
          e = (ie == 1) && ((2'(m) & st) != 0);
          check(irq == e, "R11 irq gate", 32'(irq), 32'(e));
        end
    end
    pop_one(); // still disabled -> no change
    check(cons_fill == 2, "R8 pop while disabled", 32'(cons_fill), 2);
    wr(3'd1, 32'h1); pop_one(); pop_one();
    // R12
    wr(3'd1, 32'h0F00_0002); wr(3'd2, 32'h1); settle();
    check(irq == 1, "R12 pre irq", 32'(irq), 1);
    wr(3'd3, 32'h1);
    rd(3'd3, v); check(v[0] == 0, "R12 cleared", v, 0);
    check(irq == 0, "R12 irq cleared", 32'(irq), 0);
    settle();
    rd(3'd3, v); check(v[0] == 1, "R12 reasserts", v, 1);
    check(irq == 1, "R12 irq back", 32'(irq), 1);
    n = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule